// File: doc/BRIEF.md
# Exception Entry and Return Unit

This unit sits beside the program counter and status register of a small 32-bit RISC core. It switches control into a handler when an exception is taken, and back out of the handler on a return. On an entry strobe it reads an exception code, the address to save and the present machine state word. It then writes one of two save pairs, forms the handler's state word, and computes the handler address. The address is a per-code vector entry ORed with a shared base prefix.

On a return strobe the unit reloads the program counter and the state word from either the normal pair or the critical pair. Each pair has its own masking rule. A two-bit mode input selects among three exception models:

| Mode value | Model |
|---|---|
| 0 | classic |
| 1 | early embedded |
| 2 | embedded |

The mode decides whether reserved bits are scrubbed and which pair critical-class codes use. The vector entries and the prefix are loaded through simple write ports. Every result appears one cycle after its strobe.

Top module: `exc_entry_ret`

## Requirements
- R1: After reset the following hold until the first strobe or write:
  - `redirect_valid_o`, `vec_err_o` and `checkstop_o` are 0.
  - `msr_o` and all four save-pair outputs are 0.
  - The prefix is 0 and every vector entry holds all ones, so it is undefined.
- R2: An accepted entry raises `redirect_valid_o` for exactly the one cycle after the strobe. In that cycle `redirect_pc_o` equals the vector entry for `exc_code_i` ORed with the prefix. A vector or prefix write takes effect from the next cycle.
- R3: The saved state word is written as follows:
  - In modes 0 and 1 it is `cur_msr_i` with bits 0x783F0000 forced to zero.
  - In mode 2 it is `cur_msr_i` unchanged.
- R4: The handler state word (`msr_o` after an entry) is zero except bit 12, the machine-check enable, which is copied from `cur_msr_i`.
- R5: For code 1 (machine check) taken with bit 12 set, the handler state word is entirely zero.
- R6: Code 1 with bit 12 of `cur_msr_i` clear behaves as follows:
  - It vectors nowhere and sets `checkstop_o`, which stays 1 until reset.
  - While `checkstop_o` is 1, every strobe is ignored: no redirect, and no save-pair or `msr_o` change.
- R7: An entry whose vector entry is all ones pulses `vec_err_o` for one cycle. It produces no redirect and changes no save pair and no `msr_o`.
- R8: Code 4 (floating-point program) is dropped in either of these cases. A dropped entry produces no redirect, no error and no change to any output.
  - Bits 11 and 8 of `cur_msr_i` are both 0.
  - Bit 13 of `cur_msr_i` is 0.
- R9: Codes 2 (critical input) and 3 (watchdog) pick their save pair by mode. In modes 1 and 2 they write the critical pair. In mode 0 they write the normal pair. All other codes write the normal pair.
- R10: The save-address half of the chosen pair receives `save_pc_i` unchanged.
- R11: A normal return (`ret_i` with `ret_crit_i`=0) redirects one cycle later:
  - `redirect_pc_o` is the normal saved address with bits 1:0 cleared.
  - `msr_o` is the normal saved word, with bits 0x783F0000 cleared in modes 0 and 1 and left whole in mode 2.
- R12: A critical return (`ret_crit_i`=1) redirects to the critical saved address with bits 1:0 cleared. `msr_o` is the critical saved word, masked with 0x0000FFFF in mode 1 and left whole otherwise.
- R13: When `take_i` and `ret_i` are high together, only the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Exception model: 0 classic, 1 early embedded, 2 embedded |
| take_i | input | 1 | Entry strobe |
| exc_code_i | input | 4 | Exception code, also the vector index |
| save_pc_i | input | 32 | Address to record in the save pair |
| cur_msr_i | input | 32 | Present machine state word |
| ret_i | input | 1 | Return strobe |
| ret_crit_i | input | 1 | Return from the critical pair when 1 |
| vec_we_i | input | 1 | Vector entry write enable |
| vec_idx_i | input | 4 | Vector entry index |
| vec_data_i | input | 32 | Vector entry data |
| pfx_we_i | input | 1 | Prefix write enable |
| pfx_data_i | input | 32 | Prefix data |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| msr_o | output | 32 | State word to install |
| norm_pc_o | output | 32 | Normal pair, saved address |
| norm_msr_o | output | 32 | Normal pair, saved state word |
| crit_pc_o | output | 32 | Critical pair, saved address |
| crit_msr_o | output | 32 | Critical pair, saved state word |
| vec_err_o | output | 1 | Undefined-vector pulse |
| checkstop_o | output | 1 | Sticky checkstop |

## Verification
All state is held in registers that drive the ports directly, so a wrong save-pair write shows on the pair outputs in the cycle after the strobe. A wrong mask or pair choice shows up again one cycle after a later return, through `msr_o`. Faults in the vector table only show when an entry reads the bad slot: a wrong target address, or a spurious or missing `vec_err_o`. Drops and checkstop are verified by confirming that every output holds still across the cycle after the ignored strobe.

// File: rtl/eer_pkg.sv
package eer_pkg;
    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    localparam logic [1:0] MODE_CLASSIC = 2'd0;
    localparam logic [1:0] MODE_EMB_OLD = 2'd1;
    localparam logic [1:0] MODE_EMB     = 2'd2;

    // reserved bits scrubbed from saved and restored words
    localparam word_t SAVE_MBZ     = 32'h783F_0000;
    localparam word_t CRIT_OLD_MBZ = 32'hFFFF_0000;

    localparam int BIT_ME  = 12;
    localparam int BIT_FP  = 13;
    localparam int BIT_FE0 = 11;
    localparam int BIT_FE1 = 8;

    localparam int CODE_MCHECK = 1;
    localparam int CODE_CRIT   = 2;
    localparam int CODE_WDOG   = 3;
    localparam int CODE_FPPROG = 4;

    typedef struct packed {
        logic  redir;
        word_t pc;
        word_t msr;
        word_t n_pc;
        word_t n_msr;
        word_t c_pc;
        word_t c_msr;
        logic  stop;
        logic  err;
    } eer_state_t;
endpackage

// File: rtl/eer_vec_table.sv
module eer_vec_table
    import eer_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  word_t            wdata_i,
    input  logic             pfx_we_i,
    input  word_t            pfx_data_i,
    input  logic [IDX_W-1:0] ridx_i,
    output word_t            target_o,
    output logic             undef_o
);
    word_t tbl_d [NUM_VEC];
    word_t tbl_q [NUM_VEC];
    word_t pfx_d, pfx_q;
    word_t raw;

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) begin
            tbl_d[i] = (we_i && (int'(widx_i) == i)) ? wdata_i : tbl_q[i];
        end
        pfx_d = pfx_we_i ? pfx_data_i : pfx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) tbl_q[i] <= '1;
            pfx_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            pfx_q <= pfx_d;
        end
    end

    always_comb begin
        raw = '1;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (int'(ridx_i) == i) raw = tbl_q[i];
        end
    end

    assign undef_o  = &raw;
    assign target_o = raw | pfx_q;

    AST_VEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (int'(widx_i) < NUM_VEC)) |=> (tbl_q[$past(widx_i)] == $past(wdata_i))) // R2
        else $error("vector write lost");
endmodule

// File: rtl/eer_msr_rules.sv
module eer_msr_rules
    import eer_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [1:0]        mode_i,
    input  logic [CODE_W-1:0] code_i,
    input  word_t             cur_msr_i,
    input  word_t             n_saved_i,
    input  word_t             c_saved_i,
    output word_t             save_msr_o,
    output word_t             handler_msr_o,
    output logic              use_crit_o,
    output logic              fp_drop_o,
    output logic              mc_stop_o,
    output word_t             ret_n_msr_o,
    output word_t             ret_c_msr_o
);
    localparam word_t ME_ONLY = word_t'(1) << BIT_ME;

    logic is_mc, is_crit_class, is_fp;

    always_comb begin
        is_mc         = (code_i == CODE_W'(CODE_MCHECK));
        is_crit_class = (code_i == CODE_W'(CODE_CRIT)) || (code_i == CODE_W'(CODE_WDOG));
        is_fp         = (code_i == CODE_W'(CODE_FPPROG));

        save_msr_o    = (mode_i == MODE_EMB) ? cur_msr_i : (cur_msr_i & ~SAVE_MBZ);
        handler_msr_o = is_mc ? '0 : (cur_msr_i & ME_ONLY);
        use_crit_o    = is_crit_class && (mode_i != MODE_CLASSIC);
        fp_drop_o     = is_fp && ((!cur_msr_i[BIT_FE0] && !cur_msr_i[BIT_FE1])
                                  || !cur_msr_i[BIT_FP]);
        mc_stop_o     = is_mc && !cur_msr_i[BIT_ME];

        ret_n_msr_o   = (mode_i == MODE_EMB) ? n_saved_i : (n_saved_i & ~SAVE_MBZ);
        ret_c_msr_o   = (mode_i == MODE_EMB_OLD) ? (c_saved_i & ~CRIT_OLD_MBZ) : c_saved_i;
    end
endmodule

// File: rtl/exc_entry_ret.sv
module exc_entry_ret
    import eer_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int CODE_W  = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              take_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [31:0]       save_pc_i,
    input  logic [31:0]       cur_msr_i,
    input  logic              ret_i,
    input  logic              ret_crit_i,
    input  logic              vec_we_i,
    input  logic [CODE_W-1:0] vec_idx_i,
    input  logic [31:0]       vec_data_i,
    input  logic              pfx_we_i,
    input  logic [31:0]       pfx_data_i,
    output logic              redirect_valid_o,
    output logic [31:0]       redirect_pc_o,
    output logic [31:0]       msr_o,
    output logic [31:0]       norm_pc_o,
    output logic [31:0]       norm_msr_o,
    output logic [31:0]       crit_pc_o,
    output logic [31:0]       crit_msr_o,
    output logic              vec_err_o,
    output logic              checkstop_o
);
    localparam word_t ALIGN_MASK = ~word_t'(3);
    localparam word_t ME_ONLY    = word_t'(1) << BIT_ME;

    eer_state_t st_d, st_q;

    word_t vec_target;
    logic  vec_undef;
    word_t save_msr, handler_msr, ret_n_msr, ret_c_msr;
    logic  use_crit, fp_drop, mc_stop;

    eer_vec_table #(.NUM_VEC(NUM_VEC), .IDX_W(CODE_W)) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (vec_we_i),
        .widx_i     (vec_idx_i),
        .wdata_i    (vec_data_i),
        .pfx_we_i   (pfx_we_i),
        .pfx_data_i (pfx_data_i),
        .ridx_i     (exc_code_i),
        .target_o   (vec_target),
        .undef_o    (vec_undef)
    );

    eer_msr_rules #(.CODE_W(CODE_W)) u_rules (
        .mode_i        (mode_i),
        .code_i        (exc_code_i),
        .cur_msr_i     (cur_msr_i),
        .n_saved_i     (st_q.n_msr),
        .c_saved_i     (st_q.c_msr),
        .save_msr_o    (save_msr),
        .handler_msr_o (handler_msr),
        .use_crit_o    (use_crit),
        .fp_drop_o     (fp_drop),
        .mc_stop_o     (mc_stop),
        .ret_n_msr_o   (ret_n_msr),
        .ret_c_msr_o   (ret_c_msr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        st_d.err   = 1'b0;
        if (!st_q.stop) begin
            if (take_i) begin
                if (mc_stop) begin
                    st_d.stop = 1'b1;
                end else if (fp_drop) begin
                    st_d.stop = st_q.stop;
                end else if (vec_undef) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.redir = 1'b1;
                    st_d.pc    = vec_target;
                    st_d.msr   = handler_msr;
                    if (use_crit) begin
                        st_d.c_pc  = save_pc_i;
                        st_d.c_msr = save_msr;
                    end else begin
                        st_d.n_pc  = save_pc_i;
                        st_d.n_msr = save_msr;
                    end
                end
            end else if (ret_i) begin
                st_d.redir = 1'b1;
                if (ret_crit_i) begin
                    st_d.pc  = st_q.c_pc & ALIGN_MASK;
                    st_d.msr = ret_c_msr;
                end else begin
                    st_d.pc  = st_q.n_pc & ALIGN_MASK;
                    st_d.msr = ret_n_msr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redirect_valid_o = st_q.redir;
    assign redirect_pc_o    = st_q.pc;
    assign msr_o            = st_q.msr;
    assign norm_pc_o        = st_q.n_pc;
    assign norm_msr_o       = st_q.n_msr;
    assign crit_pc_o        = st_q.c_pc;
    assign crit_msr_o       = st_q.c_msr;
    assign vec_err_o        = st_q.err;
    assign checkstop_o      = st_q.stop;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid_o && vec_err_o)) // R7
        else $error("redirect with vector error");

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> checkstop_o) // R6
        else $error("checkstop released");

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> (!redirect_valid_o && $stable(norm_pc_o) && $stable(crit_pc_o))) // R6
        else $error("activity during checkstop");

    AST_HANDLER_ME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && $past(take_i)) |-> ((msr_o & ~ME_ONLY) == '0)) // R4
        else $error("handler word carries extra bits");

    AST_RET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && !$past(take_i)) |-> (redirect_pc_o[1:0] == 2'b00)) // R11
        else $error("return target unaligned");

    AST_PAIRS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid_o |-> ($stable(norm_pc_o) && $stable(crit_pc_o) &&
                               $stable(norm_msr_o) && $stable(crit_msr_o))) // R8
        else $error("save pair changed without redirect");
endmodule

// File: tb/exc_entry_ret_bench.sv
module exc_entry_ret_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        take_i = 1'b0;
    logic [3:0]  exc_code_i = 4'd0;
    logic [31:0] save_pc_i = '0;
    logic [31:0] cur_msr_i = '0;
    logic        ret_i = 1'b0;
    logic        ret_crit_i = 1'b0;
    logic        vec_we_i = 1'b0;
    logic [3:0]  vec_idx_i = 4'd0;
    logic [31:0] vec_data_i = '0;
    logic        pfx_we_i = 1'b0;
    logic [31:0] pfx_data_i = '0;
    logic        redirect_valid_o;
    logic [31:0] redirect_pc_o, msr_o, norm_pc_o, norm_msr_o, crit_pc_o, crit_msr_o;
    logic        vec_err_o, checkstop_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    exc_entry_ret u_exc_entry_ret (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .take_i(take_i),
        .exc_code_i(exc_code_i), .save_pc_i(save_pc_i), .cur_msr_i(cur_msr_i),
        .ret_i(ret_i), .ret_crit_i(ret_crit_i), .vec_we_i(vec_we_i),
        .vec_idx_i(vec_idx_i), .vec_data_i(vec_data_i), .pfx_we_i(pfx_we_i),
        .pfx_data_i(pfx_data_i), .redirect_valid_o(redirect_valid_o),
        .redirect_pc_o(redirect_pc_o), .msr_o(msr_o), .norm_pc_o(norm_pc_o),
        .norm_msr_o(norm_msr_o), .crit_pc_o(crit_pc_o), .crit_msr_o(crit_msr_o),
        .vec_err_o(vec_err_o), .checkstop_o(checkstop_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  code;
        logic [31:0] msr;
        logic [31:0] spc;
        logic [31:0] exp_pc;
        logic [31:0] exp_hmsr;
        logic        exp_crit;
        logic [31:0] exp_smsr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd5, 32'hFFFF_FFFF, 32'h0000_2000, 32'h0001_0500, 32'h0000_1000, 1'b0, 32'h87C0_FFFF},
        '{2'd2, 4'd6, 32'h7FFF_0000, 32'h1234_5678, 32'h0001_0600, 32'h0000_0000, 1'b0, 32'h7FFF_0000},
        '{2'd1, 4'd2, 32'h783F_1000, 32'h0000_00A0, 32'h0001_0200, 32'h0000_1000, 1'b1, 32'h0000_1000},
        '{2'd2, 4'd3, 32'h783F_0001, 32'h0000_00B4, 32'h0001_0300, 32'h0000_0000, 1'b1, 32'h783F_0001},
        '{2'd0, 4'd2, 32'h0000_1001, 32'h0000_00C8, 32'h0001_0200, 32'h0000_1000, 1'b0, 32'h0000_1001},
        '{2'd0, 4'd1, 32'h0000_1000, 32'h0000_0D00, 32'h0001_0100, 32'h0000_0000, 1'b0, 32'h0000_1000},
        '{2'd0, 4'd4, 32'h0000_2800, 32'h0000_0E00, 32'h0001_0400, 32'h0000_0000, 1'b0, 32'h0000_2800},
        '{2'd0, 4'd4, 32'h0000_3100, 32'h0000_0F00, 32'h0001_0400, 32'h0000_1000, 1'b0, 32'h0000_3100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // apply strobes at a falling edge, let one rising edge pass, then clear
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        take_i = 1'b0; ret_i = 1'b0; vec_we_i = 1'b0; pfx_we_i = 1'b0;
    endtask

    task automatic enter(input logic [1:0] m, input logic [3:0] c,
                         input logic [31:0] msr, input logic [31:0] spc);
        mode_i = m; exc_code_i = c; cur_msr_i = msr; save_pc_i = spc; take_i = 1'b1;
        step();
    endtask

    task automatic leave(input logic [1:0] m, input logic crit);
        mode_i = m; ret_crit_i = crit; ret_i = 1'b1;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] keep_pc, keep_msr, keep_hmsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk("R1 msr", msr_o, 32'd0);
        chk("R1 norm pair", norm_pc_o | norm_msr_o, 32'd0);
        chk("R1 crit pair", crit_pc_o | crit_msr_o, 32'd0);
        chk("R1 checkstop", {31'd0, checkstop_o}, 32'd0);
        // R1 / R7: every vector undefined after reset
        enter(2'd0, 4'd0, 32'h0000_1000, 32'h0000_0100);
        chk("R1 R7 err after reset", {31'd0, vec_err_o}, 32'd1);
        chk("R7 no redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk("R7 pair untouched", norm_pc_o, 32'd0);
        chk("R7 msr untouched", msr_o, 32'd0);

        // program vector entries 0..14 and prefix (R2)
        for (int k = 0; k < 15; k++) begin
            vec_we_i = 1'b1; vec_idx_i = 4'(k); vec_data_i = 32'(k) * 32'h100;
            step();
        end
        pfx_we_i = 1'b1; pfx_data_i = 32'h0001_0000;
        step();

        // table walk: R2 R3 R4 R5 R9 R10
        for (int i = 0; i < NV; i++) begin
            enter(VECS[i].mode, VECS[i].code, VECS[i].msr, VECS[i].spc);
            chk("R2 redirect pulse", {31'd0, redirect_valid_o}, 32'd1);
            chk("R2 target", redirect_pc_o, VECS[i].exp_pc);
            chk("R4 R5 handler msr", msr_o, VECS[i].exp_hmsr);
            if (VECS[i].exp_crit) begin
                chk("R9 R10 crit pc", crit_pc_o, VECS[i].spc);
                chk("R3 R9 crit msr", crit_msr_o, VECS[i].exp_smsr);
            end else begin
                chk("R9 R10 norm pc", norm_pc_o, VECS[i].spc);
                chk("R3 R9 norm msr", norm_msr_o, VECS[i].exp_smsr);
            end
            @(negedge clk);
            chk("R2 single cycle", {31'd0, redirect_valid_o}, 32'd0);
        end

        // R8 floating-point drops
        keep_pc = norm_pc_o; keep_msr = norm_msr_o; keep_hmsr = msr_o;
        enter(2'd0, 4'd4, 32'h0000_3000, 32'h0000_0999);
        chk("R8 drop no redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk("R8 drop no err", {31'd0, vec_err_o}, 32'd0);
        chk("R8 drop pc kept", norm_pc_o, keep_pc);
        chk("R8 drop msr kept", norm_msr_o, keep_msr);
        chk("R8 drop handler kept", msr_o, keep_hmsr);
        enter(2'd0, 4'd4, 32'h0000_0900, 32'h0000_0998);
        chk("R8 fp off drop", {31'd0, redirect_valid_o}, 32'd0);
        chk("R8 fp off pc kept", norm_pc_o, keep_pc);

        // R7 undefined slot 15 after programming
        enter(2'd0, 4'd15, 32'h0000_1000, 32'h0000_0777);
        chk("R7 err slot 15", {31'd0, vec_err_o}, 32'd1);
        chk("R7 slot 15 no redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk("R7 slot 15 pair kept", norm_pc_o, keep_pc);
        @(negedge clk);
        chk("R7 err one cycle", {31'd0, vec_err_o}, 32'd0);

        // R11 normal return masks
        enter(2'd2, 4'd5, 32'hFFFF_FFFF, 32'h0000_3007);
        chk("R3 full save mode 2", norm_msr_o, 32'hFFFF_FFFF);
        leave(2'd0, 1'b0);
        chk("R11 redirect", {31'd0, redirect_valid_o}, 32'd1);
        chk("R11 pc aligned", redirect_pc_o, 32'h0000_3004);
        chk("R11 msr masked mode 0", msr_o, 32'h87C0_FFFF);
        leave(2'd2, 1'b0);
        chk("R11 msr whole mode 2", msr_o, 32'hFFFF_FFFF);

        // R12 critical return masks
        enter(2'd2, 4'd2, 32'hFFFF_FFFF, 32'h0000_4002);
        leave(2'd1, 1'b1);
        chk("R12 crit pc aligned", redirect_pc_o, 32'h0000_4000);
        chk("R12 crit msr mode 1", msr_o, 32'h0000_FFFF);
        leave(2'd2, 1'b1);
        chk("R12 crit msr mode 2", msr_o, 32'hFFFF_FFFF);

        // R13 entry wins over return
        ret_i = 1'b1; ret_crit_i = 1'b0;
        enter(2'd0, 4'd5, 32'h0000_1000, 32'h0000_5000);
        chk("R13 entry target", redirect_pc_o, 32'h0001_0500);
        chk("R13 entry msr", msr_o, 32'h0000_1000);
        chk("R13 save written", norm_pc_o, 32'h0000_5000);

        // R6 checkstop
        keep_pc = norm_pc_o; keep_hmsr = msr_o;
        enter(2'd0, 4'd1, 32'h0000_0000, 32'h0000_6000);
        chk("R6 checkstop set", {31'd0, checkstop_o}, 32'd1);
        chk("R6 no redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk("R6 pair kept", norm_pc_o, keep_pc);
        enter(2'd0, 4'd5, 32'h0000_1000, 32'h0000_7000);
        chk("R6 entry ignored", {31'd0, redirect_valid_o}, 32'd0);
        chk("R6 entry pair kept", norm_pc_o, keep_pc);
        leave(2'd0, 1'b0);
        chk("R6 return ignored", {31'd0, redirect_valid_o}, 32'd0);
        chk("R6 msr kept", msr_o, keep_hmsr);
        chk("R6 still stopped", {31'd0, checkstop_o}, 32'd1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset clears checkstop", {31'd0, checkstop_o}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule